// File: doc/BRIEF.md
# Latched 64-bit Timestamp Counter

This block keeps a free-running 64-bit up-counter that advances on a prescaled tick, and places it behind a plain 32-bit register write/read port. One control register carries the prescaler divide value together with two command bits. A snapshot command freezes the running count into a pair of read-back registers. Software can then fetch the high and low halves in two separate 32-bit reads and still get one coherent value. A load command presets the counter from a pair of load registers. The live count is also driven straight out on a port for local use.

Commands are handled by a small command state machine with three states. The machine sits in `IDLE` until a control write arrives. A control write whose command field is 01 moves it to `SNAP`, and one whose field is 11 moves it to `LOAD`. Any other write, or no write at all, sends it back to `IDLE`. From `SNAP` or `LOAD` the next state is decided the same way, so back-to-back commands chain directly, for example `SNAP`→`LOAD` or `SNAP`→`SNAP`. In `SNAP` the latched pair captures the count on the following clock edge. In `LOAD` the counter takes the load pair and the prescaler phase restarts from zero on that edge.

The control register fields are as follows. Bits 31:16 hold the divide value. Bits 15:2 are kept as written. Bits 1:0 are the command and read back as zero.

Top module: `tsc_timestamp`

## Requirements
- R1: While reset is asserted, the count port is zero and every mapped register reads zero: the control register at 0x68, the load pair at 0x74 (low) and 0x78 (high), and the latched pair at 0x7C (low) and 0x80 (high).
- R2: With divide value D in control bits 31:16, the counter advances by one once every D+1 clocks.
- R3: A control write with bits 1:0 equal to 01 copies the count into the latched pair on the next clock edge. The value copied is the count present during the cycle after the write edge. The latched pair reads at 0x7C (low) and 0x80 (high).
- R4: The latched pair keeps its value until the next snapshot command, while the counter keeps running.
- R5: A control write with bits 1:0 equal to 11 sets the counter to {load high, load low} on the next clock edge. The prescaler phase restarts from zero at that edge, so the first advance comes D+1 clocks later.
- R6: The command bits clear themselves: the control register reads back with bits 1:0 at zero, and bits 31:2 hold the last written value.
- R7: A control write with bits 1:0 equal to 10 issues no command. The count keeps free-running and the latched pair is left unchanged.
- R8: The counter wraps from all ones to zero and keeps counting.
- R9: Reads at 0x6C and 0x70 return the low and high halves of the live count. The load registers read back what was written to them. Any unmapped offset reads zero.
- R10: A snapshot taken right after a carry from the low half into the high half returns a pair in which both halves belong to the same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Byte offset of the register to write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the register to read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| count_o | output | 64 | Live counter value |

## Verification
Every divide value from 0 to 7 is swept. Each step loads a start value that sits four counts below a carry into the high half, and the count is compared on every clock against an arithmetic expectation. This separates a wrong tick period, an off-by-one in the phase restart after a load, and a carry fault between the halves. Snapshots are checked three ways: against the live count in the cycle after the command, against a value computed from a load just below the 32-bit boundary, and again after idle cycles to confirm they hold. A write with command field 10 that carries non-zero kept bits shows that a field which is neither command is ignored and that the kept bits survive. A load just below all ones exercises the 64-bit wrap.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;

    // Byte offsets of the register window
    localparam int unsigned OFF_CTRL    = 32'h68;
    localparam int unsigned OFF_LIVE_LO = 32'h6C;
    localparam int unsigned OFF_LIVE_HI = 32'h70;
    localparam int unsigned OFF_LOAD_LO = 32'h74;
    localparam int unsigned OFF_LOAD_HI = 32'h78;
    localparam int unsigned OFF_SNAP_LO = 32'h7C;
    localparam int unsigned OFF_SNAP_HI = 32'h80;

    // Lowest bit of the divide field inside the control word
    localparam int unsigned DIV_LSB = 16;

    // Command field encodings (control bits 1:0)
    localparam logic [1:0] CMD_SNAPSHOT = 2'b01;
    localparam logic [1:0] CMD_PRESET   = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SNAP = 2'b01,
        ST_LOAD = 2'b10
    } cmd_state_e;

endpackage

// File: rtl/tsc_prescale.sv
`timescale 1ns/1ps
module tsc_prescale #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             clear_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] phase_q;

    // A compare with >= keeps the tick period bounded when the divide
    // value is lowered below the current phase.
    assign tick_o = (phase_q >= div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/tsc_count.sv
`timescale 1ns/1ps
module tsc_count #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (tick_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/tsc_cmd_fsm.sv
`timescale 1ns/1ps
module tsc_cmd_fsm
    import tsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_i,
    input  logic [1:0] cmd_i,
    output logic       snap_o,
    output logic       load_o
);

    cmd_state_e state_q;
    cmd_state_e state_d;
    cmd_state_e req_state;

    // Which state a control write asks for
    always_comb begin
        req_state = ST_IDLE;
        if (ctrl_wr_i) begin
            if (cmd_i == CMD_SNAPSHOT) begin
                req_state = ST_SNAP;
            end else if (cmd_i == CMD_PRESET) begin
                req_state = ST_LOAD;
            end
        end
    end

    // Next-state logic: every state accepts a new command at once
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = req_state;
            ST_SNAP: state_d = req_state;
            ST_LOAD: state_d = req_state;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state alone
    always_comb begin
        snap_o = 1'b0;
        load_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                snap_o = 1'b0;
                load_o = 1'b0;
            end
            ST_SNAP: snap_o = 1'b1;
            ST_LOAD: load_o = 1'b1;
            default: begin
                snap_o = 1'b0;
                load_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tsc_regs.sv
`timescale 1ns/1ps
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIV_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    input  logic [2*DATA_W-1:0] count_i,
    input  logic                snap_i,
    output logic [DIV_W-1:0]    div_o,
    output logic                ctrl_wr_o,
    output logic [1:0]          cmd_o,
    output logic [2*DATA_W-1:0] load_val_o,
    output logic [2*DATA_W-1:0] latch_val_o
);

    localparam int unsigned CNT_W  = 2 * DATA_W;
    localparam int unsigned KEEP_W = DATA_W - 2;

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_LIVE_LO = ADDR_W'(OFF_LIVE_LO);
    localparam logic [ADDR_W-1:0] A_LIVE_HI = ADDR_W'(OFF_LIVE_HI);
    localparam logic [ADDR_W-1:0] A_LOAD_LO = ADDR_W'(OFF_LOAD_LO);
    localparam logic [ADDR_W-1:0] A_LOAD_HI = ADDR_W'(OFF_LOAD_HI);
    localparam logic [ADDR_W-1:0] A_SNAP_LO = ADDR_W'(OFF_SNAP_LO);
    localparam logic [ADDR_W-1:0] A_SNAP_HI = ADDR_W'(OFF_SNAP_HI);

    logic [KEEP_W-1:0] ctrl_q;
    logic [DATA_W-1:0] load_lo_q;
    logic [DATA_W-1:0] load_hi_q;
    logic [CNT_W-1:0]  latch_q;

    logic wr_ctrl;
    logic wr_load_lo;
    logic wr_load_hi;

    assign wr_ctrl    = wr_en_i && (wr_addr_i == A_CTRL);
    assign wr_load_lo = wr_en_i && (wr_addr_i == A_LOAD_LO);
    assign wr_load_hi = wr_en_i && (wr_addr_i == A_LOAD_HI);

    // Control word: command bits are never stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_data_i[DATA_W-1:2];
        end
    end

    // Load pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_lo_q <= '0;
            load_hi_q <= '0;
        end else begin
            if (wr_load_lo) begin
                load_lo_q <= wr_data_i;
            end
            if (wr_load_hi) begin
                load_hi_q <= wr_data_i;
            end
        end
    end

    // Latched pair, both halves captured on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (snap_i) begin
            latch_q <= count_i;
        end
    end

    assign div_o       = ctrl_q[DIV_LSB-2 +: DIV_W];
    assign ctrl_wr_o   = wr_ctrl;
    assign cmd_o       = wr_data_i[1:0];
    assign load_val_o  = {load_hi_q, load_lo_q};
    assign latch_val_o = latch_q;

    // Read mux
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL:    rd_data_o = {ctrl_q, 2'b00};
            A_LIVE_LO: rd_data_o = count_i[DATA_W-1:0];
            A_LIVE_HI: rd_data_o = count_i[CNT_W-1:DATA_W];
            A_LOAD_LO: rd_data_o = load_lo_q;
            A_LOAD_HI: rd_data_o = load_hi_q;
            A_SNAP_LO: rd_data_o = latch_q[DATA_W-1:0];
            A_SNAP_HI: rd_data_o = latch_q[CNT_W-1:DATA_W];
            default:   rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/tsc_timestamp.sv
`timescale 1ns/1ps
module tsc_timestamp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIV_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [2*DATA_W-1:0] count_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic             tick;
    logic             snap_pulse;
    logic             load_pulse;
    logic             ctrl_wr;
    logic [1:0]       cmd;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] latch_val;
    logic [CNT_W-1:0] count;

    tsc_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .count_i     (count),
        .snap_i      (snap_pulse),
        .div_o       (div),
        .ctrl_wr_o   (ctrl_wr),
        .cmd_o       (cmd),
        .load_val_o  (load_val),
        .latch_val_o (latch_val)
    );

    tsc_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (ctrl_wr),
        .cmd_i     (cmd),
        .snap_o    (snap_pulse),
        .load_o    (load_pulse)
    );

    tsc_prescale #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_i   (div),
        .clear_i (load_pulse),
        .tick_o  (tick)
    );

    tsc_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load_pulse),
        .load_val_i (load_val),
        .count_o    (count)
    );

    assign count_o = count;

endmodule

// File: rtl/tsc_timestamp_chk.sv
`timescale 1ns/1ps
module tsc_timestamp_chk
    import tsc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIV_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                tick,
    input logic                snap_pulse,
    input logic                load_pulse,
    input logic [DIV_W-1:0]    div,
    input logic [2*DATA_W-1:0] load_val,
    input logic [2*DATA_W-1:0] latch_val,
    input logic [2*DATA_W-1:0] count
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic ctrl_write;
    assign ctrl_write = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_pulse) |=> (count == $past(count) + CNT_W'(1)));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_pulse) |=> $stable(count));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse |=> (latch_val == $past(count)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_pulse |=> $stable(latch_val));

    p_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (count == $past(load_val)));

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && !ctrl_write) |=> (tick == (div == '0)));

    p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snap_pulse, load_pulse}));

    p_no_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && wr_data[1:0] == 2'b10) |=> (!snap_pulse && !load_pulse));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_pulse && (&count)) |=> (count == '0));

endmodule

bind tsc_timestamp tsc_timestamp_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DIV_W  (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .tick       (tick),
    .snap_pulse (snap_pulse),
    .load_pulse (load_pulse),
    .div        (div),
    .load_val   (load_val),
    .latch_val  (latch_val),
    .count      (count)
);

// File: tb/tsc_timestamp_test.sv
`timescale 1ns/1ps
module tsc_timestamp_test;

    localparam logic [7:0] R_CTRL    = 8'h68;
    localparam logic [7:0] R_LIVE_LO = 8'h6C;
    localparam logic [7:0] R_LIVE_HI = 8'h70;
    localparam logic [7:0] R_LOAD_LO = 8'h74;
    localparam logic [7:0] R_LOAD_HI = 8'h78;
    localparam logic [7:0] R_SNAP_LO = 8'h7C;
    localparam logic [7:0] R_SNAP_HI = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] count_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tsc_timestamp uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .count_o (count_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic read_latch(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(R_SNAP_HI, hi);
        rd(R_SNAP_LO, lo);
        v = {hi, lo};
    endtask

    // Preset the counter with divide d; returns in the cycle where count == l
    task automatic preset(input logic [15:0] d, input logic [63:0] l);
        wr(R_LOAD_LO, l[31:0]);
        wr(R_LOAD_HI, l[63:32]);
        wr(R_CTRL, {d, 14'h0, 2'b11});
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] l, exp, snap;
        int c0;
        logic [63:0] k0;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 count in reset", count_o, 64'h0);
        rd(R_CTRL, v);    chk("R1 ctrl", {32'h0, v}, 64'h0);
        rd(R_LOAD_LO, v); chk("R1 load lo", {32'h0, v}, 64'h0);
        rd(R_LOAD_HI, v); chk("R1 load hi", {32'h0, v}, 64'h0);
        rd(R_SNAP_LO, v); chk("R1 latch lo", {32'h0, v}, 64'h0);
        rd(R_SNAP_HI, v); chk("R1 latch hi", {32'h0, v}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9: live reads and unmapped offsets
        rd(R_LIVE_LO, v); chk("R9 live lo", {32'h0, v}, {32'h0, count_o[31:0]});
        rd(R_LIVE_HI, v); chk("R9 live hi", {32'h0, v}, {32'h0, count_o[63:32]});
        rd(8'h00, v);     chk("R9 unmapped 00", {32'h0, v}, 64'h0);
        rd(8'h84, v);     chk("R9 unmapped 84", {32'h0, v}, 64'h0);
        rd(8'h6A, v);     chk("R9 unmapped 6A", {32'h0, v}, 64'h0);

        // R7 and R6: command field 10 is ignored, kept bits survive
        @(negedge clk);
        c0 = cyc; k0 = count_o;
        wr(R_CTRL, 32'h0000_ABC2);
        repeat (2) @(negedge clk);
        chk("R7 count free-runs", count_o, k0 + 64'(cyc - c0));
        rd(R_CTRL, v); chk("R6 ctrl readback", {32'h0, v}, 64'h0000_0000_0000_ABC0);
        read_latch(snap); chk("R7 latch untouched", snap, 64'h0);

        // R9 load readback, R5 preset with kept bits, R6
        wr(R_LOAD_LO, 32'h1357_9BDF);
        wr(R_LOAD_HI, 32'h2468_ACE0);
        rd(R_LOAD_LO, v); chk("R9 load lo readback", {32'h0, v}, 64'h1357_9BDF);
        rd(R_LOAD_HI, v); chk("R9 load hi readback", {32'h0, v}, 64'h2468_ACE0);
        wr(R_CTRL, 32'h0000_5557);
        @(negedge clk);
        chk("R5 preset value", count_o, 64'h2468_ACE0_1357_9BDF);
        rd(R_CTRL, v); chk("R6 ctrl clears cmd", {32'h0, v}, 64'h0000_0000_0000_5554);

        // R2/R5 sweep over divide values, R3 and R4 snapshots
        for (int d = 0; d < 8; d++) begin
            l = {8'h00, 8'(d), 16'h0000, 32'hFFFF_FFFC};
            preset(16'(d), l);
            chk("R5 preset in sweep", count_o, l);
            for (int m = 1; m <= 5 * (d + 1); m++) begin
                @(negedge clk);
                chk("R2 tick period", count_o, l + 64'(m / (d + 1)));
            end
            wr(R_CTRL, {16'(d), 14'h0, 2'b01});
            exp = count_o;
            @(negedge clk);
            read_latch(snap); chk("R3 snapshot value", snap, exp);
            repeat (10) @(negedge clk);
            read_latch(snap); chk("R4 latch holds", snap, exp);
        end

        // R10: snapshot just after carry into high half
        preset(16'h0, 64'h0000_0000_FFFF_FFFE);
        wr(R_CTRL, 32'h0000_0001);
        @(negedge clk);
        rd(R_SNAP_HI, v); chk("R10 coherent hi", {32'h0, v}, 64'h1);
        rd(R_SNAP_LO, v); chk("R10 coherent lo", {32'h0, v}, 64'h0);

        // R8: 64-bit wrap
        preset(16'h0, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R8 before wrap", count_o, 64'hFFFF_FFFF_FFFF_FFFE);
        @(negedge clk);
        chk("R8 all ones", count_o, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        chk("R8 wrapped", count_o, 64'h0);
        @(negedge clk);
        chk("R8 after wrap", count_o, 64'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule